// File: doc/BRIEF.md
# Calendar Real-Time-Clock Register Block

This block is a small memory-mapped clock-calendar. It has a 32-bit word bus with valid, write, address, write-data and read-data signals. It holds a packed date word, a packed time word, a control/status word and a bank of general-purpose scratch words. Software sets the clock by writing the date and the time words. Each write raises its own flag in the control/status word. A read of that word returns the flags and clears them in the same access, so software can see whether either word was written since it last looked.

A once-per-second enable input advances the calendar. Seconds carry into minutes and minutes into hours. Hours carry into the day of the month and into a seven-value weekday. Day overflow follows the length of the current month, including leap years, and a December overflow bumps the year offset. The year is stored as an offset from the `BASE_YEAR` parameter.

The `LAYOUT` parameter selects one of two address maps, A or B. The other offsets in the 1 KiB window (oscillator, alarm, power and similar) hold no state: they read back zero and ignore writes.

Top module: `cal_rtc_regs`

## Requirements
- R1: After a synchronous active-low reset, the control/status word and all scratch words read 0. If `BASE_YEAR` > 1900, the date and time words read the initial calendar value given by the `INIT_*` parameters. Otherwise they read 0.
- R2: A valid read presents its data on `bus_rdata` one cycle later. `bus_rdata` holds its value in cycles with no read.
- R3: The control/status word is at offset 0x000. A write to the date word sets bit 7 of it, and a write to the time word sets bit 8. No other bit of it is ever 1.
- R4: A read of the control/status word returns bits 7 and 8 as they stood before the read, and clears both bits.
- R5: Scratch words keep what is written to them and return it on a read. Layout A (`LAYOUT`=0) has 4 of them at 0x020 + 4·i. Layout B (`LAYOUT`=1) has 8 of them at 0x100 + 4·i.
- R6: Layout A places the date at 0x004 and the time at 0x008. Layout B places the date at 0x010 and the time at 0x014.
- R7: The following read as 0 and discard writes: unassigned offsets, offsets that are not word-aligned, offsets past the scratch bank, and the control/status word as a write target.
- R8: Each cycle with `tick_1hz` high advances the time word. Field positions are: second [7:0], minute [15:8], hour [23:16], weekday [31:29] (0 = Monday, 6 = Sunday). A second of 59 wraps to 0 and carries a minute. A minute of 59 wraps to 0 and carries an hour. An hour of 23 wraps to 0, advances the day and steps the weekday (6 wraps to 0).
- R9: Date fields are: year offset [31:16], month [15:8] (1 to 12), day [7:0]. On a day carry, the day past the month's length wraps to 1. April, June, September and November have 30 days. February has 29 days when `BASE_YEAR` + offset is divisible by 4, and 28 otherwise.
- R10: A day carry out of the last day of month 12 sets the month to 1, the day to 1 and increments the year offset.
- R11: A tick in the same cycle as a write has these effects. A write to the time word replaces the tick entirely: the time takes the written value and the date does not advance. A write to the date word stores the written value, while the time still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second that advances the calendar |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the 1 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |

## Verification
The hardest situation to reach from the ports is a full carry chain. That means a tick at second 59, minute 59, hour 23 on the last day of a month, and most of all at 31 December or on 28/29 February in leap and non-leap years. Such a state arises only after a matching date and time have been loaded. The stimulus writes random calendar values biased toward those edges (second 59, minute 59, hour 23, the last day of the month, month 12), issues a few ticks and compares against a bench model. Directed cases add the leap-day boundaries and a tick coinciding with date or time writes.

// File: rtl/rtc_pkg.sv
// Shared types and helpers for the calendar RTC register block.
// Assumes month values 1..12; any other month is treated as 31 days long.
package rtc_pkg;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_CTRL,
        KIND_DATE,
        KIND_TIME,
        KIND_SCRATCH
    } rtc_kind_e;

    localparam int FLAG_DATE_BIT = 7;
    localparam int FLAG_TIME_BIT = 8;

    // Number of days in a month, given whether the year is a leap year.
    function automatic logic [7:0] month_days(input logic [7:0] month, input logic leap);
        logic [7:0] n;
        case (month)
            8'd2:                        n = leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:     n = 8'd30;
            default:                     n = 8'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_addr_decode.sv
// Address decoder: maps a byte offset to a register kind and scratch index.
// LAYOUT selects the map. Unaligned and unassigned offsets decode as none.
module rtc_addr_decode #(
    parameter int LAYOUT    = 0,
    parameter int ADDR_W    = 10,
    parameter int GP_IDX_W  = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output rtc_pkg::rtc_kind_e  kind,
    output logic [GP_IDX_W-1:0] gp_idx
);
    import rtc_pkg::*;

    localparam int DATE_OFF = (LAYOUT == 0) ? 'h004 : 'h010;
    localparam int TIME_OFF = (LAYOUT == 0) ? 'h008 : 'h014;
    localparam int GP_BASE  = (LAYOUT == 0) ? 'h020 : 'h100;
    localparam int GP_COUNT = (LAYOUT == 0) ? 4 : 8;
    localparam int GP_END   = GP_BASE + 4 * GP_COUNT;

    logic [ADDR_W-1:0] gp_rel;

    // Offset relative to the scratch bank base.
    assign gp_rel = addr - ADDR_W'(GP_BASE);

    // Classify the offset.
    always_comb begin
        kind   = KIND_NONE;
        gp_idx = GP_IDX_W'(gp_rel >> 2);
        if (addr[1:0] == 2'b00) begin
            if (addr == ADDR_W'(0))
                kind = KIND_CTRL;
            else if (addr == ADDR_W'(DATE_OFF))
                kind = KIND_DATE;
            else if (addr == ADDR_W'(TIME_OFF))
                kind = KIND_TIME;
            else if (32'(addr) >= GP_BASE && 32'(addr) < GP_END)
                kind = KIND_SCRATCH;
        end
    end

endmodule

// File: rtl/rtc_scratch.sv
// Bank of general-purpose words: write by index, read by index.
// Assumes wr_idx and rd_idx are below COUNT whenever they are used.
module rtc_scratch #(
    parameter int COUNT  = 4,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] words [COUNT];

    for (genvar g = 0; g < COUNT; g++) begin : g_word
        // One scratch word: cleared by reset, loaded on its own write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                words[g] <= wr_data;
        end
    end

    // Select the addressed word.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < COUNT; i++)
            if (rd_idx == IDX_W'(i))
                rd_data = words[i];
    end

endmodule

// File: rtl/rtc_calendar.sv
// Time and date words with per-second advance and the full carry chain.
// Stores whole written words. A tick rewrites only the counting fields,
// so bits outside the fields keep their written values.
module rtc_calendar #(
    parameter int          BASE_YEAR = 2010,
    parameter logic [31:0] INIT_DATE = '0,
    parameter logic [31:0] INIT_TIME = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_date,
    input  logic        wr_time,
    input  logic [31:0] wdata,
    output logic [31:0] date_q,
    output logic [31:0] time_q
);
    import rtc_pkg::*;

    localparam bit         LOAD_INIT = (BASE_YEAR > 1900);
    localparam logic [1:0] BASE_MOD4 = 2'(BASE_YEAR % 4);

    logic [31:0] time_adv;
    logic [31:0] date_adv;
    logic        day_carry;
    logic        leap;
    logic [7:0]  dim;

    // Advance the time fields by one second; flag a carry into the day.
    always_comb begin
        time_adv  = time_q;
        day_carry = 1'b0;
        if (time_q[7:0] >= 8'd59) begin
            time_adv[7:0] = 8'd0;
            if (time_q[15:8] >= 8'd59) begin
                time_adv[15:8] = 8'd0;
                if (time_q[23:16] >= 8'd23) begin
                    time_adv[23:16] = 8'd0;
                    time_adv[31:29] = (time_q[31:29] >= 3'd6) ? 3'd0 : time_q[31:29] + 3'd1;
                    day_carry       = 1'b1;
                end else begin
                    time_adv[23:16] = time_q[23:16] + 8'd1;
                end
            end else begin
                time_adv[15:8] = time_q[15:8] + 8'd1;
            end
        end else begin
            time_adv[7:0] = time_q[7:0] + 8'd1;
        end
    end

    // Advance the date by one day with month length and year rollover.
    always_comb begin
        leap     = (2'(date_q[17:16] + BASE_MOD4) == 2'd0);
        dim      = month_days(date_q[15:8], leap);
        date_adv = date_q;
        if (date_q[7:0] >= dim) begin
            date_adv[7:0] = 8'd1;
            if (date_q[15:8] >= 8'd12) begin
                date_adv[15:8]  = 8'd1;
                date_adv[31:16] = date_q[31:16] + 16'd1;
            end else begin
                date_adv[15:8] = date_q[15:8] + 8'd1;
            end
        end else begin
            date_adv[7:0] = date_q[7:0] + 8'd1;
        end
    end

    // Time register: a bus write wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            time_q <= LOAD_INIT ? INIT_TIME : 32'd0;
        else if (wr_time)
            time_q <= wdata;
        else if (tick)
            time_q <= time_adv;
    end

    // Date register: a bus write wins; a day carry counts only if time ticked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            date_q <= LOAD_INIT ? INIT_DATE : 32'd0;
        else if (wr_date)
            date_q <= wdata;
        else if (tick && day_carry && !wr_time)
            date_q <= date_adv;
    end

endmodule

// File: rtl/cal_rtc_regs.sv
// Top level of the calendar RTC register block: decodes the bus, keeps
// the written flags (set on write, clear on read) and registers the read data.
// Assumes one access per cycle and full 32-bit words only.
module cal_rtc_regs #(
    parameter int LAYOUT     = 0,
    parameter int ADDR_W     = 10,
    parameter int BASE_YEAR  = (LAYOUT == 0) ? 2010 : 1970,
    parameter int INIT_YOFF  = 15,
    parameter int INIT_MONTH = 6,
    parameter int INIT_DAY   = 30,
    parameter int INIT_WDAY  = 2,
    parameter int INIT_HOUR  = 23,
    parameter int INIT_MIN   = 59,
    parameter int INIT_SEC   = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    import rtc_pkg::*;

    localparam int          GP_COUNT  = (LAYOUT == 0) ? 4 : 8;
    localparam int          GP_IDX_W  = $clog2(GP_COUNT);
    localparam logic [31:0] INIT_DATE = {16'(INIT_YOFF), 8'(INIT_MONTH), 8'(INIT_DAY)};
    localparam logic [31:0] INIT_TIME = {3'(INIT_WDAY), 5'd0, 8'(INIT_HOUR),
                                         8'(INIT_MIN), 8'(INIT_SEC)};

    rtc_kind_e             kind;
    logic [GP_IDX_W-1:0]   gp_idx;
    logic                  wr_acc;
    logic                  rd_acc;
    logic [1:0]            flags_q;
    logic [31:0]           date_q;
    logic [31:0]           time_q;
    logic [31:0]           gp_rd;
    logic [31:0]           rd_mux;
    logic [31:0]           rdata_q;

    assign wr_acc = bus_valid && bus_write;
    assign rd_acc = bus_valid && !bus_write;

    rtc_addr_decode #(
        .LAYOUT   (LAYOUT),
        .ADDR_W   (ADDR_W),
        .GP_IDX_W (GP_IDX_W)
    ) u_dec (
        .addr   (bus_addr),
        .kind   (kind),
        .gp_idx (gp_idx)
    );

    rtc_scratch #(
        .COUNT  (GP_COUNT),
        .IDX_W  (GP_IDX_W),
        .DATA_W (32)
    ) u_gp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_acc && kind == KIND_SCRATCH),
        .wr_idx  (gp_idx),
        .wr_data (bus_wdata),
        .rd_idx  (gp_idx),
        .rd_data (gp_rd)
    );

    rtc_calendar #(
        .BASE_YEAR (BASE_YEAR),
        .INIT_DATE (INIT_DATE),
        .INIT_TIME (INIT_TIME)
    ) u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .wr_date (wr_acc && kind == KIND_DATE),
        .wr_time (wr_acc && kind == KIND_TIME),
        .wdata   (bus_wdata),
        .date_q  (date_q),
        .time_q  (time_q)
    );

    // Written flags: bit 0 = date, bit 1 = time; a control read clears both.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= 2'b00;
        else if (rd_acc && kind == KIND_CTRL)
            flags_q <= 2'b00;
        else if (wr_acc)
            flags_q <= flags_q | {kind == KIND_TIME, kind == KIND_DATE};
    end

    // Read data source for the addressed offset.
    always_comb begin
        rd_mux = '0;
        case (kind)
            KIND_CTRL: begin
                rd_mux[FLAG_DATE_BIT] = flags_q[0];
                rd_mux[FLAG_TIME_BIT] = flags_q[1];
            end
            KIND_DATE:    rd_mux = date_q;
            KIND_TIME:    rd_mux = time_q;
            KIND_SCRATCH: rd_mux = gp_rd;
            default:      rd_mux = '0;
        endcase
    end

    // Read data register: loads only on a read access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_acc)
            rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/cal_rtc_regs_chk.sv
// Property checker for cal_rtc_regs, attached with bind.
// Decodes the date and time offsets on its own from LAYOUT.
module cal_rtc_regs_chk #(
    parameter int LAYOUT = 0,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [1:0]        flags_q,
    input logic [31:0]       date_q,
    input logic [31:0]       time_q
);
    localparam logic [ADDR_W-1:0] C_DATE = ADDR_W'((LAYOUT == 0) ? 'h004 : 'h010);
    localparam logic [ADDR_W-1:0] C_TIME = ADDR_W'((LAYOUT == 0) ? 'h008 : 'h014);

    logic wr_time_c;
    assign wr_time_c = bus_valid && bus_write && bus_addr == C_TIME;

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

    p_date_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == C_DATE) |=> flags_q[0]);

    p_time_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_time_c |=> flags_q[1]);

    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == '0) |=> (flags_q == 2'b00));

    p_sec_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !wr_time_c && time_q[7:0] < 8'd59)
        |=> (time_q[7:0] == $past(time_q[7:0]) + 8'd1));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !(bus_valid && bus_write)) |=> ($stable(time_q) && $stable(date_q)));

    p_time_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_time_c |=> (time_q == $past(bus_wdata)));

endmodule

bind cal_rtc_regs cal_rtc_regs_chk #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1hz  (tick_1hz),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .flags_q   (flags_q),
    .date_q    (date_q),
    .time_q    (time_q)
);

// File: tb/cal_rtc_regs_test.sv
// Bench: layout A (base 2010) as uut, layout B (base 1900, no init load) as uut_b.
module cal_rtc_regs_test;

    localparam int BASE = 2010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_tick = 1'b0, a_valid = 1'b0, a_write = 1'b0;
    logic [9:0]  a_addr = '0;
    logic [31:0] a_wdata = '0, a_rdata;
    logic        b_valid = 1'b0, b_write = 1'b0;
    logic [9:0]  b_addr = '0;
    logic [31:0] b_wdata = '0, b_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    cal_rtc_regs #(.LAYOUT(0), .BASE_YEAR(BASE), .INIT_YOFF(15), .INIT_MONTH(6),
                   .INIT_DAY(30), .INIT_WDAY(2), .INIT_HOUR(23), .INIT_MIN(59),
                   .INIT_SEC(50)) uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(a_tick), .bus_valid(a_valid),
        .bus_write(a_write), .bus_addr(a_addr), .bus_wdata(a_wdata), .bus_rdata(a_rdata));

    cal_rtc_regs #(.LAYOUT(1), .BASE_YEAR(1900)) uut_b (
        .clk(clk), .rst_n(rst_n), .tick_1hz(1'b0), .bus_valid(b_valid),
        .bus_write(b_write), .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(b_rdata));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr_a(input logic [9:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        a_valid = 1'b1; a_write = 1'b1; a_addr = a; a_wdata = d; a_tick = tk;
        @(negedge clk);
        a_valid = 1'b0; a_write = 1'b0; a_tick = 1'b0;
    endtask

    task automatic rd_a(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        a_valid = 1'b1; a_write = 1'b0; a_addr = a;
        @(negedge clk);
        a_valid = 1'b0;
        d = a_rdata;
    endtask

    task automatic wr_b(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        b_valid = 1'b1; b_write = 1'b1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_valid = 1'b0; b_write = 1'b0;
    endtask

    task automatic rd_b(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        b_valid = 1'b1; b_write = 1'b0; b_addr = a;
        @(negedge clk);
        b_valid = 1'b0;
        d = b_rdata;
    endtask

    task automatic tick_a();
        @(negedge clk);
        a_tick = 1'b1;
        @(negedge clk);
        a_tick = 1'b0;
    endtask

    function automatic int mdays(input int mo, input int yoff);
        if (mo == 2) return ((BASE + yoff) % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] pk_time(input int w, input int h, input int m, input int s);
        return {3'(w), 5'd0, 8'(h), 8'(m), 8'(s)};
    endfunction

    function automatic logic [31:0] pk_date(input int y, input int mo, input int d);
        return {16'(y), 8'(mo), 8'(d)};
    endfunction

    // Reference model of one second of calendar advance.
    task automatic model_tick(inout logic [31:0] d, inout logic [31:0] t);
        int s = int'(t[7:0]); int m = int'(t[15:8]); int h = int'(t[23:16]);
        int w = int'(t[31:29]);
        int y = int'(d[31:16]); int mo = int'(d[15:8]); int dy = int'(d[7:0]);
        s++;
        if (s == 60) begin
            s = 0; m++;
            if (m == 60) begin
                m = 0; h++;
                if (h == 24) begin
                    h = 0; w = (w + 1) % 7; dy++;
                    if (dy > mdays(mo, y)) begin
                        dy = 1; mo++;
                        if (mo > 12) begin mo = 1; y++; end
                    end
                end
            end
        end
        t = pk_time(w, h, m, s);
        d = pk_date(y, mo, dy);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r, ed, et;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd_a(10'h000, r); check("R1 ctrl", r, 32'h0);
        rd_a(10'h004, r); check("R1 date init", r, pk_date(15, 6, 30));
        rd_a(10'h008, r); check("R1 time init", r, pk_time(2, 23, 59, 50));
        rd_a(10'h020, r); check("R1 gp0", r, 32'h0);
        rd_b(10'h010, r); check("R1 date no init", r, 32'h0);
        rd_b(10'h014, r); check("R1 time no init", r, 32'h0);

        // R2: read data holds without a read
        rd_a(10'h004, r);
        repeat (3) @(negedge clk);
        check("R2 rdata hold", a_rdata, pk_date(15, 6, 30));

        // R8 / R9: 30 June 23:59:50 plus ten ticks -> 1 July 00:00:00, weekday 3
        repeat (10) tick_a();
        rd_a(10'h008, r); check("R8 time carry", r, pk_time(3, 0, 0, 0));
        rd_a(10'h004, r); check("R9 30-day month", r, pk_date(15, 7, 1));

        // R3 / R4: flags set on write, read then cleared
        wr_a(10'h004, pk_date(2, 2, 29), 1'b0);
        rd_a(10'h000, r); check("R3 date flag", r, 32'h0000_0080);
        rd_a(10'h000, r); check("R4 cleared", r, 32'h0);
        wr_a(10'h008, pk_time(6, 23, 59, 59), 1'b0);
        rd_a(10'h000, r); check("R3 time flag", r, 32'h0000_0100);
        // R9 leap: 2012-02-29 23:59:59 Sunday -> 1 March, Monday
        tick_a();
        rd_a(10'h004, r); check("R9 leap feb", r, pk_date(2, 3, 1));
        rd_a(10'h008, r); check("R8 weekday wrap", r, pk_time(0, 0, 0, 0));
        // R9 non-leap: 2011-02-28 -> 1 March
        wr_a(10'h004, pk_date(1, 2, 28), 1'b0);
        wr_a(10'h008, pk_time(1, 23, 59, 59), 1'b0);
        tick_a();
        rd_a(10'h004, r); check("R9 nonleap feb", r, pk_date(1, 3, 1));
        // R10: 31 December rollover
        wr_a(10'h004, pk_date(7, 12, 31), 1'b0);
        wr_a(10'h008, pk_time(4, 23, 59, 59), 1'b0);
        tick_a();
        rd_a(10'h004, r); check("R10 new year", r, pk_date(8, 1, 1));

        // R11: time write with tick -> written value, date unchanged
        wr_a(10'h008, pk_time(5, 23, 59, 59), 1'b0);
        wr_a(10'h008, pk_time(5, 23, 59, 59), 1'b1);
        rd_a(10'h008, r); check("R11 time wins", r, pk_time(5, 23, 59, 59));
        rd_a(10'h004, r); check("R11 no date carry", r, pk_date(8, 1, 1));
        // R11: date write with tick -> date written, time advances
        wr_a(10'h004, pk_date(9, 5, 31), 1'b1);
        rd_a(10'h004, r); check("R11 date wins", r, pk_date(9, 5, 31));
        rd_a(10'h008, r); check("R11 time ticks", r, pk_time(6, 0, 0, 0));
        rd_a(10'h000, r); check("R11 flags", r, 32'h0000_0180);

        // R5 / R7: scratch words and ignored offsets, layout A
        for (int i = 0; i < 4; i++) wr_a(10'(32'h020 + 4 * i), 32'hA500_0000 + 32'(i), 1'b0);
        wr_a(10'h00C, 32'hFFFF_FFFF, 1'b0);
        wr_a(10'h030, 32'hFFFF_FFFF, 1'b0);
        wr_a(10'h022, 32'hFFFF_FFFF, 1'b0);
        wr_a(10'h000, 32'hFFFF_FFFF, 1'b0);
        for (int i = 0; i < 4; i++) begin
            rd_a(10'(32'h020 + 4 * i), r); check("R5 gp A", r, 32'hA500_0000 + 32'(i));
        end
        rd_a(10'h00C, r); check("R7 alarm reads 0", r, 32'h0);
        rd_a(10'h030, r); check("R7 past bank", r, 32'h0);
        rd_a(10'h022, r); check("R7 unaligned", r, 32'h0);
        rd_a(10'h000, r); check("R7 ctrl write ignored", r, 32'h0);

        // R5 / R6 / R7: layout B
        wr_b(10'h010, pk_date(50, 3, 4));
        wr_b(10'h014, pk_time(1, 2, 3, 4));
        wr_b(10'h11C, 32'h1234_5678);
        wr_b(10'h004, 32'hFFFF_FFFF);
        rd_b(10'h010, r); check("R6 B date", r, pk_date(50, 3, 4));
        rd_b(10'h014, r); check("R6 B time", r, pk_time(1, 2, 3, 4));
        rd_b(10'h11C, r); check("R5 gp B last", r, 32'h1234_5678);
        rd_b(10'h004, r); check("R7 B unassigned", r, 32'h0);
        rd_b(10'h000, r); check("R3 B flags", r, 32'h0000_0180);
        rd_a(10'h010, r); check("R6 A 0x010 unmapped", r, 32'h0);

        // R8 / R9 / R10: random calendar values biased toward carries
        for (int it = 0; it < 60; it++) begin
            int y = int'($urandom_range(0, 40));
            int mo = ($urandom_range(0, 2) == 0) ? 12 : int'($urandom_range(1, 12));
            int dy = ($urandom_range(0, 1) == 1) ? mdays(mo, y) : int'($urandom_range(1, mdays(mo, y)));
            int h = ($urandom_range(0, 1) == 1) ? 23 : int'($urandom_range(0, 23));
            int m = ($urandom_range(0, 1) == 1) ? 59 : int'($urandom_range(0, 59));
            int s = ($urandom_range(0, 1) == 1) ? 59 : int'($urandom_range(50, 59));
            int w = int'($urandom_range(0, 6));
            int n = int'($urandom_range(1, 3));
            ed = pk_date(y, mo, dy);
            et = pk_time(w, h, m, s);
            wr_a(10'h004, ed, 1'b0);
            wr_a(10'h008, et, 1'b0);
            for (int k = 0; k < n; k++) begin
                tick_a();
                model_tick(ed, et);
            end
            rd_a(10'h008, r); check("R8 random time", r, et);
            rd_a(10'h004, r); check("R9 R10 random date", r, ed);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule